// File: doc/BRIEF.md
# Calendar Alarm and Periodic Interrupt Unit

This block sits next to a calendar clock and turns its time into interrupt requests. Five alarm fields hold second, minute, hour, date and month values. Each field has its own enable for the comparison, so a field that is not enabled matches any time. The current time fields arrive from the calendar counter as inputs. The alarm compare runs only when the calendar signals that a one-second update has finished.

A 15-bit prescaler counts 32.768 kHz time-base ticks. A 4-bit rate code picks one of its bits as the periodic tap. Every rising edge of that tap raises the periodic flag. The update pulse raises the update-ended flag, and a successful alarm compare raises the alarm flag. Each flag is set whether or not its interrupt enable is on. An active-low interrupt request goes low whenever a set flag has its enable on.

A CPU register port gives access to the alarm fields, the control register and the status register. Reading the status register returns the flags and clears them. The request pin is also reported in the status register.

Top module: `clk_alarm_irq`

## Requirements
- R1: After reset, irq_n is 1. Addresses 0 to 5 read 0x00 and address 6 (status) reads 0x80.
- R2: Addresses 0 to 4 are the alarm fields for second, minute, hour, date and month, and read back as written. Address 5 (control) holds enables in bits 6:4 and the rate code in bits 3:0, and bit 7 always reads 0.
- R3: On an update pulse, the alarm flag (status bit 5) sets when every alarm field with bit 7 set equals the matching current field in bits 6:0. For the hour this covers both the PM bit 6 and the hour bits 5:0. When no field is enabled, every update pulse sets the flag.
- R4: While no update pulse arrives, the alarm flag does not set, even when the alarm and the time match.
- R5: Every update pulse sets the update-ended flag (status bit 4).
- R6: Rate code 0 never sets the periodic flag (status bit 6). Code c from 1 to 15 sets it on each rising edge of bit c-1 of a counter that advances once per time-base tick. This gives 32768/2^c Hz.
- R7: All flags set regardless of their enables.
- R8: A read of status returns the flags and clears them. A read of any other address leaves them unchanged.
- R9: A flag event in the same cycle as a status read is kept, and the next status read shows it.
- R10: irq_n and status bit 7 are 0 exactly when some flag is set and its enable is on: periodic with control bit 6, alarm with bit 5, update-ended with bit 4.
- R11: A write to the status address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz time-base period |
| upd_pulse | input | 1 | One-cycle pulse when a second update has finished |
| cur_sec | input | 7 | Current seconds |
| cur_min | input | 7 | Current minutes |
| cur_hour | input | 7 | Current hour, bit 6 PM, bits 5:0 hour |
| cur_date | input | 7 | Current date of month |
| cur_month | input | 7 | Current month |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A status read that clears the flags can fall in the same cycle as an update pulse that sets the update-ended flag and, with a matching alarm, the alarm flag. The bench drives the read strobe and the update pulse on the same cycle. It checks that the data returned in that cycle shows the flags as they were before the event. It then checks that a second read shows both new flags, so the event was not lost to the clear. The same kind of overlap between a rate-code change and the periodic tap is handled by letting the tap settle and clearing before each rate is swept.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
   localparam int unsigned FLD_W  = 7;
   localparam int unsigned N_FLD  = 5;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned RATE_W = 4;
   localparam int unsigned DIV_W  = 15;
   localparam int unsigned N_FLAG = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

   localparam int unsigned FL_UPD = 0;
   localparam int unsigned FL_ALM = 1;
   localparam int unsigned FL_PER = 2;

   typedef logic [N_FLAG-1:0] flag_vec_t;
endpackage

// File: rtl/clk_alarm_cmp.sv
module clk_alarm_cmp #(
   parameter int unsigned N_FLD = 5,
   parameter int unsigned FLD_W = 7
) (
   input  logic [N_FLD-1:0]            en_i,
   input  logic [N_FLD-1:0][FLD_W-1:0] alm_i,
   input  logic [N_FLD-1:0][FLD_W-1:0] cur_i,
   output logic                        hit_o
);
   logic [N_FLD-1:0] fld_ok;

   initial begin
      assert (N_FLD >= 1 && FLD_W >= 1)
         else $error("clk_alarm_cmp: empty field set");
   end

   for (genvar i = 0; i < N_FLD; i++) begin : g_fld
      // a disabled field is a don't-care
      assign fld_ok[i] = !en_i[i] || (alm_i[i] == cur_i[i]);
   end

   assign hit_o = &fld_ok;
endmodule

// File: rtl/clk_alarm_rate.sv
module clk_alarm_rate #(
   parameter int unsigned DIV_W  = 15,
   parameter int unsigned RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [RATE_W-1:0] code_i,
   output logic              rise_o
);
   localparam int unsigned N_TAP = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q;
   logic [N_TAP-1:0] taps;
   logic             tap;
   logic             tap_q;

   initial begin
      assert (DIV_W == (1 << RATE_W) - 1)
         else $error("clk_alarm_rate: DIV_W must equal 2**RATE_W-1");
   end

   // code 0 selects the constant zero in position 0
   assign taps = {cnt_q, 1'b0};
   assign tap  = taps[code_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tap_q <= 1'b0;
      end else begin
         if (tick_i) cnt_q <= cnt_q + 1'b1;
         tap_q <= tap;
      end
   end

   assign rise_o = tap & ~tap_q;

   assert_rate_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o && $stable(code_i)) |-> $past(tick_i));
endmodule

// File: rtl/clk_alarm_flags.sv
module clk_alarm_flags #(
   parameter int unsigned N_FLAG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_FLAG-1:0] set_i,
   input  logic              clr_i,
   output logic [N_FLAG-1:0] flags_o
);
   logic [N_FLAG-1:0] flags_q;

   for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags_q[i] <= 1'b0;
         else if (set_i[i]) flags_q[i] <= 1'b1;   // set wins over clear
         else if (clr_i)    flags_q[i] <= 1'b0;
      end
   end

   assign flags_o = flags_q;

   assert_set_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/clk_alarm_irq.sv
module clk_alarm_irq
   import clk_alarm_pkg::*;
#(
   parameter int unsigned P_FLD_W  = FLD_W,
   parameter int unsigned P_N_FLD  = N_FLD,
   parameter int unsigned P_RATE_W = RATE_W,
   parameter int unsigned P_DIV_W  = DIV_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_32k,
   input  logic               upd_pulse,
   input  logic [P_FLD_W-1:0] cur_sec,
   input  logic [P_FLD_W-1:0] cur_min,
   input  logic [P_FLD_W-1:0] cur_hour,
   input  logic [P_FLD_W-1:0] cur_date,
   input  logic [P_FLD_W-1:0] cur_month,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic               irq_n
);
   localparam int unsigned LOW_W = REG_W - 1 - N_FLAG;

   logic [P_N_FLD-1:0][REG_W-1:0]   alm_q;
   logic [P_N_FLD-1:0]              alm_en;
   logic [P_N_FLD-1:0][P_FLD_W-1:0] alm_val;
   logic [P_N_FLD-1:0][P_FLD_W-1:0] cur_all;
   flag_vec_t                       en_q;
   logic [P_RATE_W-1:0]             rate_q;
   flag_vec_t                       flags;
   flag_vec_t                       set_v;
   logic                            hit;
   logic                            per_rise;
   logic                            stat_rd;

   initial begin
      assert (REG_W == P_FLD_W + 1)
         else $error("clk_alarm_irq: field plus enable must fill a register");
      assert (P_N_FLD == 5)
         else $error("clk_alarm_irq: five time fields expected at the ports");
      assert (LOW_W == P_RATE_W)
         else $error("clk_alarm_irq: rate code must fill control bits below enables");
   end

   assign cur_all = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

   for (genvar i = 0; i < P_N_FLD; i++) begin : g_alm
      assign alm_en[i]  = alm_q[i][REG_W-1];
      assign alm_val[i] = alm_q[i][P_FLD_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alm_q[i] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(i))
            alm_q[i] <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         rate_q <= '0;
      end else if (reg_wr && reg_addr == A_CTRL) begin
         en_q   <= reg_wdata[REG_W-2 -: N_FLAG];
         rate_q <= reg_wdata[P_RATE_W-1:0];
      end
   end

   clk_alarm_cmp #(.N_FLD(P_N_FLD), .FLD_W(P_FLD_W)) u_cmp (
      .en_i  (alm_en),
      .alm_i (alm_val),
      .cur_i (cur_all),
      .hit_o (hit)
   );

   clk_alarm_rate #(.DIV_W(P_DIV_W), .RATE_W(P_RATE_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_32k),
      .code_i (rate_q),
      .rise_o (per_rise)
   );

   always_comb begin
      set_v         = '0;
      set_v[FL_UPD] = upd_pulse;
      set_v[FL_ALM] = upd_pulse & hit;
      set_v[FL_PER] = per_rise;
   end

   assign stat_rd = reg_rd && (reg_addr == A_STAT);

   clk_alarm_flags #(.N_FLAG(N_FLAG)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_v),
      .clr_i   (stat_rd),
      .flags_o (flags)
   );

   assign irq_n = ~|(flags & en_q);

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < P_N_FLD; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = alm_q[i];
      end
      if (reg_addr == A_CTRL) reg_rdata = {1'b0, en_q, rate_q};
      if (reg_addr == A_STAT) reg_rdata = {irq_n, flags, {LOW_W{1'b0}}};
   end

   assert_alarm_on_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |=> !$rose(flags[FL_ALM]));

   assert_update_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |=> flags[FL_UPD]);

   assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_STAT && set_v == '0 && !stat_rd) |=> (flags == $past(flags)));
endmodule

// File: tb/clk_alarm_irq_tb.sv
module clk_alarm_irq_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic       upd_pulse = 1'b0;
   logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_n;

   int n_cmp = 0;
   int n_bad = 0;
   logic [14:0] cnt_m = '0;
   logic        pf_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_alarm_irq u_dut (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .upd_pulse(upd_pulse),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_date(cur_date), .cur_month(cur_month),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_upd();
      @(negedge clk);
      upd_pulse = 1'b1;
      @(negedge clk);
      upd_pulse = 1'b0;
   endtask

   task automatic one_tick(input int code);
      logic [14:0] old;
      @(negedge clk);
      tick_32k = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0;
      @(negedge clk);
      old = cnt_m;
      cnt_m = cnt_m + 15'd1;
      if (code != 0 && cnt_m[code-1] && !old[code-1]) pf_m = 1'b1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic logic [6:0] fval(input int i);
      return 7'((8'h13 * i) + 8'h21);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      for (int a = 0; a < 6; a++) begin
         rd_reg(3'(a), d);
         chk("R1 reg", d, 8'h00);
      end
      rd_reg(3'd6, d);
      chk("R1 status", d, 8'h80);

      // R2 readback
      for (int a = 0; a < 5; a++) wr_reg(3'(a), 8'(8'h5A ^ (a * 8'h31)));
      for (int a = 0; a < 5; a++) begin
         rd_reg(3'(a), d);
         chk("R2 alarm readback", d, 8'(8'h5A ^ (a * 8'h31)));
      end
      wr_reg(3'd5, 8'hFF);
      rd_reg(3'd5, d);
      chk("R2 control bit7 zero", d, 8'h7F);
      wr_reg(3'd5, 8'h00);

      // R3 / R5 sweep over enable masks and mismatching field
      for (int m = 0; m < 32; m++) begin
         for (int j = 0; j < 6; j++) begin
            logic [6:0] cv [5];
            logic       af;
            for (int i = 0; i < 5; i++) begin
               wr_reg(3'(i), {m[i] ? 1'b1 : 1'b0, fval(i)});
               cv[i] = fval(i);
               if (i == j) cv[i] = fval(i) ^ ((i == 2) ? 7'h40 : 7'h01);
            end
            @(negedge clk);
            cur_sec = cv[0]; cur_min = cv[1]; cur_hour = cv[2];
            cur_date = cv[3]; cur_month = cv[4];
            pulse_upd();
            af = (j == 5) || !m[j];
            rd_reg(3'd6, d);
            chk("R3 R5 alarm compare", d, {1'b1, 1'b0, af, 1'b1, 4'b0});
         end
      end

      // R4 full match held, no update pulse
      for (int i = 0; i < 5; i++) wr_reg(3'(i), {1'b1, fval(i)});
      @(negedge clk);
      cur_sec = fval(0); cur_min = fval(1); cur_hour = fval(2);
      cur_date = fval(3); cur_month = fval(4);
      repeat (4) @(negedge clk);
      rd_reg(3'd6, d);
      chk("R4 no update no alarm", d, 8'h80);
      pulse_upd();
      rd_reg(3'd6, d);
      chk("R4 update gives alarm", d, 8'hB0);

      // R9 update in the same cycle as a status read
      @(negedge clk);
      reg_addr = 3'd6; reg_rd = 1'b1; upd_pulse = 1'b1;
      #1 d0 = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; upd_pulse = 1'b0;
      chk("R9 read sees old flags", d0, 8'h80);
      rd_reg(3'd6, d);
      chk("R9 coinciding event kept", d, 8'hB0);

      // R8 other reads do not clear
      pulse_upd();
      rd_reg(3'd0, d);
      rd_reg(3'd5, d);
      rd_reg(3'd6, d);
      chk("R8 flags after other reads", d, 8'hB0);
      rd_reg(3'd6, d);
      chk("R8 cleared by status read", d, 8'h80);

      // R11 status write ignored
      pulse_upd();
      wr_reg(3'd6, 8'h00);
      rd_reg(3'd6, d);
      chk("R11 status write ignored", d, 8'hB0);

      // R7 / R10 masking
      pulse_upd();
      chk("R7 flags set with enables off irq_n", {7'b0, irq_n}, 8'h01);
      wr_reg(3'd5, 8'h40);
      chk("R10 periodic enable only irq_n", {7'b0, irq_n}, 8'h01);
      wr_reg(3'd5, 8'h10);
      chk("R10 update enable irq_n", {7'b0, irq_n}, 8'h00);
      rd_reg(3'd6, d);
      chk("R10 status bit7 low", d, 8'h30);
      chk("R10 irq_n after clear", {7'b0, irq_n}, 8'h01);
      wr_reg(3'd5, 8'h20);
      pulse_upd();
      chk("R10 alarm enable irq_n", {7'b0, irq_n}, 8'h00);
      rd_reg(3'd6, d);
      chk("R10 alarm status", d, 8'h30);

      // R6 periodic rate sweep
      for (int code = 0; code < 7; code++) begin
         wr_reg(3'd5, 8'(8'h40 | code));
         @(negedge clk);
         rd_reg(3'd6, d);
         pf_m = 1'b0;
         for (int t = 0; t < 140; t++) begin
            one_tick(code);
            chk($sformatf("R6 code %0d irq_n", code), {7'b0, irq_n}, {7'b0, ~pf_m});
            if (pf_m) begin
               rd_reg(3'd6, d);
               chk($sformatf("R6 code %0d status", code), d, 8'h40);
               pf_m = 1'b0;
            end
         end
      end
      wr_reg(3'd5, 8'h00);

      finish_run();
   end
endmodule